// File: doc/BRIEF.md
# Command Descriptor Register Loader

This block sets up one channel of a memory-to-memory DMA engine from a packed command descriptor. A descriptor arrives as a run of 32-bit words on a valid/ready stream. The first word is a header bitmask. Every recognised set bit in the header claims exactly one of the words that follow. That word goes to the channel register named by the bit, and the words are taken in ascending bit order. Header bits that are clear, reserved, or the clear-request bit claim no word.

For each payload word the loader raises a one-cycle write strobe toward the channel register file. The strobe carries the register index, which is the header bit position, together with the word. Header bit 0 raises a one-cycle clear pulse, so the register file zeroes its contents before any write of that descriptor. Once the last selected word has been written, the loader pulses a channel-enable command and goes back to waiting for a header.

The loader does not fetch descriptors from memory. It keeps its own copy of the two link-address words and presents the address with its follow-on flag, so a fetch unit outside the block can chain to the next descriptor.

Top module: `cmdlink_loader`

## Requirements
- R1: After reset the loader is idle: `busy`, `wr_en`, `clr`, `enable` and `link_en` are 0, `in_ready` is 1, and `link_addr` is 0.
- R2: When idle, the loader takes the next stream word as a header. `busy` rises in the cycle after the header is taken and falls in the same cycle that `enable` pulses. While `busy` is high, every word taken is payload and never a header.
- R3: The selectable header bits are 2 (interrupt enable), 3 (control), 4/5 (source address low/high), 6/7 (destination address low/high), 8/9 (count low/high), 10/11 (source/destination transfer config), 12 (address increment), 14 (fill value), 19/20 (source/destination trigger config), 29 (auto-restart config) and 30/31 (link address low/high). A payload word taken at a clock edge produces exactly one `wr_en` cycle right after that edge. In that cycle `wr_idx` equals the header bit position and `wr_data` equals the word.
- R4: Payload words are assigned to the set selectable bits in ascending bit order, one word per bit.
- R5: Bit 0 and the reserved bits (1, 13, 15–18, 21–28) never claim a payload word. A header with no selectable bit set produces no write strobe.
- R6: A header with bit 0 set produces a one-cycle `clr` pulse in the cycle right after the header is taken. This comes before any write strobe of that descriptor. The pulse also zeroes the stored link address.
- R7: `enable` is a one-cycle pulse. It comes in the cycle right after the last write strobe of a descriptor. If the header selects no register, it comes two cycles after the header is taken.
- R8: The word for bit 30 is stored as the link low word and the word for bit 31 as the link high word. `link_en` equals bit 0 of the stored low word, and `link_addr` is {high, low} with bit 0 forced to 0. The stored values persist across descriptors that do not select them.
- R9: `in_ready` is 1 whenever `busy` is 0. While `busy` is 1, `in_ready` is 1 only while payload words are still owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Stream word accepted when high with `in_valid` |
| in_data | input | W | Stream word (header or payload) |
| busy | output | 1 | A descriptor is being loaded |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | $clog2(W) | Target register index (header bit position) |
| wr_data | output | W | Register write data |
| clr | output | 1 | Clear-all-registers pulse |
| enable | output | 1 | Channel enable command pulse |
| link_addr | output | 2*W | Stored next-descriptor address, bit 0 zero |
| link_en | output | 1 | Next descriptor follows |

## Verification
The bench builds the loader with its default parameters: a 32-bit word and the default selectable-bit mask. This puts all seventeen register slots and every reserved position within reach. Directed descriptors cover an empty clear-only header with cycle-exact pulse timing, a header made only of reserved bits, a fully populated header, and link words with odd and even low words. A follow-up header checks that nothing stale was consumed. Random headers, built by ANDing two random words so they are sparse, are sent with random stream gaps. Each one is checked strobe by strobe against a queue the bench fills from its own list of selectable bits.

// File: rtl/cmdlink_loader.sv
module cmdlink_loader #(
  parameter int W = 32,
  parameter logic [W-1:0] SEL_MASK = 32'hE018_5FFC,
  parameter int CLR_BIT = 0,
  parameter int LINK_LO_BIT = 30,
  parameter int LINK_HI_BIT = 31,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          busy,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [W-1:0]  wr_data,
  output logic          clr,
  output logic          enable,
  output logic [2*W-1:0] link_addr,
  output logic          link_en
);

  logic [W-1:0]  pend_q;
  logic [IW-1:0] nxt;
  logic [W-1:0]  lnk_lo_q, lnk_hi_q;

  always_comb begin
    nxt = '0;
    for (int i = W - 1; i >= 0; i--)
      if (pend_q[i]) nxt = IW'(i);
  end

  assign in_ready  = busy ? (pend_q != '0) : 1'b1;
  assign link_en   = lnk_lo_q[0];
  assign link_addr = {lnk_hi_q, lnk_lo_q[W-1:1], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      pend_q   <= '0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      clr      <= 1'b0;
      enable   <= 1'b0;
      lnk_lo_q <= '0;
      lnk_hi_q <= '0;
    end else begin
      wr_en  <= 1'b0;
      clr    <= 1'b0;
      enable <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          busy   <= 1'b1;
          pend_q <= in_data & SEL_MASK;
          clr    <= in_data[CLR_BIT];
          if (in_data[CLR_BIT]) begin
            lnk_lo_q <= '0;
            lnk_hi_q <= '0;
          end
        end
      end else if (pend_q == '0) begin
        busy   <= 1'b0;
        enable <= 1'b1;
      end else if (in_valid) begin
        wr_en   <= 1'b1;
        wr_idx  <= nxt;
        wr_data <= in_data;
        pend_q  <= pend_q & (pend_q - 1'b1);
        if (nxt == IW'(LINK_LO_BIT)) lnk_lo_q <= in_data;
        if (nxt == IW'(LINK_HI_BIT)) lnk_hi_q <= in_data;
      end
    end
  end

endmodule

// File: rtl/cmdlink_loader_chk.sv
module cmdlink_loader_chk #(
  parameter int W = 32,
  parameter logic [W-1:0] SEL_MASK = 32'hE018_5FFC,
  parameter int CLR_BIT = 0,
  localparam int IW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [W-1:0]  in_data,
  input logic          busy,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic          clr,
  input logic          enable
);

  p_idle_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> in_ready);

  p_enable_ends_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> (!busy && $past(busy)));

  p_strobe_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(busy && in_valid && in_ready));

  p_payload_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid && in_ready) |=> wr_en);

  p_index_selectable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (SEL_MASK[wr_idx] == 1'b1));

  p_clr_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> ($past(!busy && in_valid && in_data[CLR_BIT]) && !wr_en));

  p_enable_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> !enable);

endmodule

bind cmdlink_loader cmdlink_loader_chk #(.W(W), .SEL_MASK(SEL_MASK), .CLR_BIT(CLR_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .busy(busy), .wr_en(wr_en), .wr_idx(wr_idx),
  .clr(clr), .enable(enable)
);

// File: tb/cmdlink_loader_tb.sv
`timescale 1ns/1ps
module cmdlink_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        busy, wr_en, clr, enable, link_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic [63:0] link_addr;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int last_wr_cyc = 0;
  int wr_cnt = 0;
  bit exp_clr = 0;
  bit clr_seen = 0;
  logic [31:0] m_lo = '0, m_hi = '0;
  logic [4:0]  exp_idx[$];
  logic [31:0] exp_dat[$];

  cmdlink_loader u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .busy(busy), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .clr(clr), .enable(enable), .link_addr(link_addr),
    .link_en(link_en)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic bit selectable(int b);
    return (b >= 2 && b <= 12) || b == 14 || b == 19 || b == 20 || b >= 29;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin
      wr_cnt++;
      last_wr_cyc = cyc;
      chk(busy == 1'b1, "R2", "busy during strobe", 64'(busy), 64'd1);
      if (exp_idx.size() == 0) begin
        chk(1'b0, "R3", "unexpected strobe idx", 64'(wr_idx), 64'hFF);
      end else begin
        logic [4:0]  ei;
        logic [31:0] ed;
        ei = exp_idx.pop_front();
        ed = exp_dat.pop_front();
        chk(wr_idx == ei, "R4", "strobe index order", 64'(wr_idx), 64'(ei));
        chk(wr_data == ed, "R3", "strobe data", 64'(wr_data), 64'(ed));
      end
    end
    if (clr) begin
      clr_seen = 1;
      chk(exp_clr && wr_cnt == 0, "R6", "clear before writes", 64'(wr_cnt), 64'd0);
    end
  end

  task automatic send(logic [31:0] w);
    bit rdy;
    repeat ($urandom % 3) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    forever begin
      rdy = in_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    #1 in_valid = 1'b0;
  endtask

  task automatic run_desc(logic [31:0] hdr, logic [31:0] lo_word);
    logic [31:0] wq[$];
    int n;
    bit got;
    exp_clr = hdr[0];
    clr_seen = 0;
    wr_cnt = 0;
    if (hdr[0]) begin m_lo = '0; m_hi = '0; end
    for (int b = 0; b < 32; b++) begin
      if (selectable(b) && hdr[b]) begin
        logic [31:0] w;
        w = (b == 30) ? lo_word : $urandom;
        exp_idx.push_back(5'(b));
        exp_dat.push_back(w);
        wq.push_back(w);
        if (b == 30) m_lo = w;
        if (b == 31) m_hi = w;
      end
    end
    n = wq.size();
    send(hdr);
    foreach (wq[k]) send(wq[k]);
    got = 0;
    for (int k = 0; k < 8 && !got; k++) begin
      @(negedge clk);
      if (enable) got = 1;
    end
    chk(got, "R7", "enable seen", 64'(got), 64'd1);
    if (n > 0) chk(cyc == last_wr_cyc + 1, "R7", "enable follows last strobe", 64'(cyc), 64'(last_wr_cyc + 1));
    chk(exp_idx.size() == 0, "R4", "all words consumed", 64'(exp_idx.size()), 64'd0);
    chk(wr_cnt == n, "R5", "strobe count", 64'(wr_cnt), 64'(n));
    chk(clr_seen == hdr[0], "R6", "clear pulse presence", 64'(clr_seen), 64'(hdr[0]));
    chk(busy == 1'b0, "R2", "busy drops with enable", 64'(busy), 64'd0);
    chk(link_en == m_lo[0], "R8", "link enable", 64'(link_en), 64'(m_lo[0]));
    chk(link_addr == {m_hi, m_lo[31:1], 1'b0}, "R8", "link address", link_addr, {m_hi, m_lo[31:1], 1'b0});
    exp_idx.delete();
    exp_dat.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && wr_en == 0 && clr == 0 && enable == 0, "R1", "reset outputs",
        {busy, wr_en, clr, enable}, 64'd0);
    chk(in_ready == 1'b1, "R1", "reset ready", 64'(in_ready), 64'd1);
    chk(link_en == 0 && link_addr == 0, "R1", "reset link", link_addr, 64'd0);

    exp_clr = 1; clr_seen = 0; wr_cnt = 0;
    in_valid = 1'b1; in_data = 32'h0000_0001;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    chk(clr == 1'b1, "R6", "clear pulse timing", 64'(clr), 64'd1);
    chk(busy == 1'b1 && in_ready == 1'b0, "R9", "no ready with nothing owed", {busy, in_ready}, 64'b10);
    chk(enable == 1'b0, "R7", "no early enable", 64'(enable), 64'd0);
    @(negedge clk);
    chk(enable == 1'b1 && busy == 1'b0 && clr == 1'b0, "R7", "empty header enable", {enable, busy, clr}, 64'b100);
    chk(in_ready == 1'b1, "R9", "ready when idle", 64'(in_ready), 64'd1);
    @(negedge clk);
    chk(enable == 1'b0, "R7", "enable single cycle", 64'(enable), 64'd0);

    run_desc(32'h0000_0008, 32'h0);
    run_desc(32'h1FE7_A002, 32'h0);
    run_desc(32'h0000_0008, 32'h0);
    run_desc(32'hFFFF_FFFF, 32'h1234_5671);
    run_desc(32'h0000_0300, 32'h0);
    run_desc(32'h0000_0011, 32'h0);
    run_desc(32'h4000_0000, 32'h8000_0000);
    run_desc(32'hC000_0000, 32'hABCD_0003);

    for (int i = 0; i < 80; i++) begin
      logic [31:0] h;
      h = $urandom & $urandom;
      if (($urandom % 4) == 0) h[0] = 1'b1;
      run_desc(h, $urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule